// File: doc/BRIEF.md
# Four-word-burst separate-port SRAM controller

This block drives a synchronous SRAM that has separate read and write data ports, moves data on both clock edges, and transfers four words per access. On the user side it takes read requests (address only) and write requests (address, four data words and a per-lane write enable for each word). Each request side has a small FIFO with a ready/valid handshake. On the memory side it drives active-low read and write port selects, one address bus shared by both ports, and write data with active-low lane selects. It captures returned read data, qualified by a per-half valid strobe, and assembles it into one wide response.

Both data directions are presented as edge pairs, one word for the rising half and one for the falling half of each controller clock. The pad-level double-rate registers and the echo-clock capture sit outside the block. Read data from the memory arrives two and a half cycles after the read select is sampled. The controller stores a word only in a half whose valid strobe is high, so it depends on the strobe rather than on a fixed delay.

Top module: `qdr4_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `mem_rps_n` and `mem_wps_n` are 1, `rsp_valid` is 0 and every lane select is 1.
- R2: A write request accepted at clock edge a drives `mem_wps_n` low for exactly one cycle, after edge a+1, with the request address on `mem_addr`.
- R3: Write word w sits at `wr_data[36w+35:36w]` and its enable for lane i at `wr_be[4w+i]`. The edge after the select brings words 0 and 1 (rising half, falling half), and the edge after that brings words 2 and 3. `*_bws_n[i]` is the inverted enable and governs bits 9i+8:9i.
- R4: A lane whose enable is 0 is not written and keeps its stored value, which a later read returns.
- R5: A read request accepted at edge a drives `mem_rps_n` low for exactly one cycle, after edge a+1, with the request address on `mem_addr`.
- R6: A read word is captured only in a half whose valid strobe is high. Captured word k goes to `rsp_data[36k+35:36k]`. `rsp_valid` pulses for one cycle, seven cycles after the accepting edge when the memory returns data with its fixed latency.
- R7: Read responses return in the order the read requests were accepted.
- R8: Neither port select is low in two consecutive cycles.
- R9: At most one select is low in any cycle. When both ports are eligible, grants alternate between read and write.
- R10: A read request and a write request offered in the same cycle are both accepted at that edge and both complete.
- R11: `wr_ready` falls when the write FIFO is full. A held request is not lost and is issued once space frees.
- R12: Outside the two data cycles of a write burst, all lane selects are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, in phase with the memory's positive clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write FIFO has space |
| wr_addr | input | AW | Write burst address |
| wr_data | input | 4*DW | Four write words, word 0 lowest |
| wr_be | input | 4*LANES | Active-high lane enables, bit 4w+i for word w lane i |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read FIFO has space |
| rd_addr | input | AW | Read burst address |
| rsp_valid | output | 1 | One-cycle pulse, response data valid |
| rsp_data | output | 4*DW | Four read words, first captured lowest |
| mem_rps_n | output | 1 | Active-low read port select |
| mem_wps_n | output | 1 | Active-low write port select |
| mem_addr | output | AW | Shared address bus |
| mem_d_rise | output | DW | Write word for the rising half |
| mem_d_fall | output | DW | Write word for the falling half |
| mem_bws_n_rise | output | LANES | Active-low lane selects, rising half |
| mem_bws_n_fall | output | LANES | Active-low lane selects, falling half |
| mem_q_rise | input | DW | Read word captured on the rising half |
| mem_q_fall | input | DW | Read word captured on the falling half |
| mem_qvld_rise | input | 1 | Valid strobe for the rising-half word |
| mem_qvld_fall | input | 1 | Valid strobe for the falling-half word |

## Verification
Two things can fall in the same cycle. The first is a read grant and a write grant competing for the one address bus. The second is the last word of one read burst and the first word of the next, which arrive in the rising and falling halves of a single capture cycle. The bench provokes the first by offering a read and a write at the same edge, and a per-cycle monitor judges it: it requires that the two selects are never low together and that both requests finish with correct data. It provokes the second by back-to-back reads, whose data a behavioural memory returns with the stated latency and with junk on halves that are not valid. Each response is judged word by word against a reference array.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
  // words per access and controller cycles per access
  localparam int BURST = 4;
  localparam int BEATS = BURST / 2;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_RD   = 2'd1,
    GNT_WR   = 2'd2
  } gnt_e;
endpackage

// File: rtl/qdr4_fifo.sv
module qdr4_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp];

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/qdr4_sched.sv
module qdr4_sched
  import qdr4_pkg::*;
#(
  parameter int AW    = 19,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_head_v,
  input  logic [AW-1:0]          rd_head_addr,
  input  logic                   wr_head_v,
  input  logic [AW-1:0]          wr_head_addr,
  input  logic [BURST*DW-1:0]    wr_head_data,
  input  logic [BURST*LANES-1:0] wr_head_be,
  output logic                   rd_pop,
  output logic                   wr_pop,
  output logic                   mem_rps_n,
  output logic                   mem_wps_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_d_rise,
  output logic [DW-1:0]          mem_d_fall,
  output logic [LANES-1:0]       mem_bws_n_rise,
  output logic [LANES-1:0]       mem_bws_n_fall
);
  logic rd_gap, wr_gap, last_rd, can_rd, can_wr;
  gnt_e gnt;

  logic [BURST*DW-1:0]    hold_data;
  logic [BURST*LANES-1:0] hold_be;
  logic [1:0]             wbeat;
  int unsigned            w0;

  // a port that issued last cycle is still busy with its burst
  always_comb begin
    can_rd = rd_head_v && !rd_gap;
    can_wr = wr_head_v && !wr_gap;
    if (can_rd && can_wr)  gnt = last_rd ? GNT_WR : GNT_RD;
    else if (can_rd)       gnt = GNT_RD;
    else if (can_wr)       gnt = GNT_WR;
    else                   gnt = GNT_NONE;
  end

  assign rd_pop = (gnt == GNT_RD);
  assign wr_pop = (gnt == GNT_WR);
  assign w0     = (wbeat == 2'd2) ? 32'd2 : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gap    <= 1'b0;
      wr_gap    <= 1'b0;
      last_rd   <= 1'b0;
      mem_rps_n <= 1'b1;
      mem_wps_n <= 1'b1;
      mem_addr  <= '0;
    end else begin
      rd_gap    <= rd_pop;
      wr_gap    <= wr_pop;
      if (gnt != GNT_NONE) last_rd <= rd_pop;
      mem_rps_n <= !rd_pop;
      mem_wps_n <= !wr_pop;
      if (rd_pop)      mem_addr <= rd_head_addr;
      else if (wr_pop) mem_addr <= wr_head_addr;
    end
  end

  // burst holding register, no reset needed
  always_ff @(posedge clk) begin
    if (wr_pop) begin
      hold_data <= wr_head_data;
      hold_be   <= wr_head_be;
    end
  end

  // two data beats follow each write select
  always_ff @(posedge clk) begin
    if (rst) begin
      wbeat          <= '0;
      mem_d_rise     <= '0;
      mem_d_fall     <= '0;
      mem_bws_n_rise <= '1;
      mem_bws_n_fall <= '1;
    end else begin
      if (wbeat != 2'd0) begin
        mem_d_rise     <= hold_data[DW*w0 +: DW];
        mem_d_fall     <= hold_data[DW*(w0+1) +: DW];
        mem_bws_n_rise <= ~hold_be[LANES*w0 +: LANES];
        mem_bws_n_fall <= ~hold_be[LANES*(w0+1) +: LANES];
        wbeat          <= (wbeat == 2'(BEATS)) ? 2'd0 : wbeat + 2'd1;
      end else begin
        mem_d_rise     <= '0;
        mem_d_fall     <= '0;
        mem_bws_n_rise <= '1;
        mem_bws_n_fall <= '1;
      end
      if (wr_pop) wbeat <= 2'd1;
    end
  end
endmodule

// File: rtl/qdr4_rd_capture.sv
module qdr4_rd_capture
  import qdr4_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       q_rise,
  input  logic [DW-1:0]       q_fall,
  input  logic                vld_rise,
  input  logic                vld_fall,
  output logic                rsp_valid,
  output logic [BURST*DW-1:0] rsp_data
);
  localparam int KW = $clog2(BURST);

  logic [DW-1:0]       slot   [BURST];
  logic [DW-1:0]       slot_n [BURST];
  logic [KW-1:0]       cnt, cnt_n;
  logic                done;
  logic [BURST*DW-1:0] done_data;
  logic [DW-1:0]       half_q [2];
  logic                half_v [2];

  assign half_q[0] = q_rise;
  assign half_q[1] = q_fall;
  assign half_v[0] = vld_rise;
  assign half_v[1] = vld_fall;

  // rising half precedes falling half in time; a burst may end in either
  always_comb begin
    slot_n    = slot;
    cnt_n     = cnt;
    done      = 1'b0;
    done_data = '0;
    for (int h = 0; h < 2; h++) begin
      if (half_v[h]) begin
        slot_n[cnt_n] = half_q[h];
        if (cnt_n == KW'(BURST - 1)) begin
          done = 1'b1;
          for (int k = 0; k < BURST; k++) done_data[DW*k +: DW] = slot_n[k];
          cnt_n = '0;
        end else begin
          cnt_n = cnt_n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    slot <= slot_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      cnt       <= cnt_n;
      rsp_valid <= done;
      if (done) rsp_data <= done_data;
    end
  end
endmodule

// File: rtl/qdr4_ctrl.sv
module qdr4_ctrl
  import qdr4_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 36,
  parameter int LANES      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [AW-1:0]          wr_addr,
  input  logic [BURST*DW-1:0]    wr_data,
  input  logic [BURST*LANES-1:0] wr_be,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [AW-1:0]          rd_addr,
  output logic                   rsp_valid,
  output logic [BURST*DW-1:0]    rsp_data,
  output logic                   mem_rps_n,
  output logic                   mem_wps_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_d_rise,
  output logic [DW-1:0]          mem_d_fall,
  output logic [LANES-1:0]       mem_bws_n_rise,
  output logic [LANES-1:0]       mem_bws_n_fall,
  input  logic [DW-1:0]          mem_q_rise,
  input  logic [DW-1:0]          mem_q_fall,
  input  logic                   mem_qvld_rise,
  input  logic                   mem_qvld_fall
);
  localparam int WFW = AW + BURST*DW + BURST*LANES;

  logic           wf_full, wf_empty, rf_full, rf_empty, rd_pop, wr_pop;
  logic [WFW-1:0] wf_head;
  logic [AW-1:0]  rf_head;

  assign wr_ready = !wf_full;
  assign rd_ready = !rf_full;

  qdr4_fifo #(.W(WFW), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst(rst),
    .push(wr_valid), .din({wr_addr, wr_data, wr_be}),
    .pop(wr_pop), .dout(wf_head), .full(wf_full), .empty(wf_empty)
  );

  qdr4_fifo #(.W(AW), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst(rst),
    .push(rd_valid), .din(rd_addr),
    .pop(rd_pop), .dout(rf_head), .full(rf_full), .empty(rf_empty)
  );

  qdr4_sched #(.AW(AW), .DW(DW), .LANES(LANES)) u_sched (
    .clk(clk), .rst(rst),
    .rd_head_v(!rf_empty), .rd_head_addr(rf_head),
    .wr_head_v(!wf_empty),
    .wr_head_addr(wf_head[WFW-1 -: AW]),
    .wr_head_data(wf_head[BURST*LANES +: BURST*DW]),
    .wr_head_be(wf_head[BURST*LANES-1:0]),
    .rd_pop(rd_pop), .wr_pop(wr_pop),
    .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n), .mem_addr(mem_addr),
    .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
    .mem_bws_n_rise(mem_bws_n_rise), .mem_bws_n_fall(mem_bws_n_fall)
  );

  qdr4_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst),
    .q_rise(mem_q_rise), .q_fall(mem_q_fall),
    .vld_rise(mem_qvld_rise), .vld_fall(mem_qvld_fall),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/qdr4_ctrl_chk.sv
module qdr4_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rps_n,
  input logic             mem_wps_n,
  input logic [LANES-1:0] mem_bws_n_rise,
  input logic [LANES-1:0] mem_bws_n_fall,
  input logic             rsp_valid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mem_rps_n && mem_wps_n && !rsp_valid && (&mem_bws_n_rise) && (&mem_bws_n_fall)));

  // R8
  rd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rps_n |=> mem_rps_n);

  // R8
  wr_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_wps_n |=> mem_wps_n);

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rps_n || mem_wps_n);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12
  bws_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !((&mem_bws_n_rise) && (&mem_bws_n_fall)) |-> (!$past(mem_wps_n) || !$past(mem_wps_n, 2)));
endmodule

bind qdr4_ctrl qdr4_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .mem_rps_n(mem_rps_n), .mem_wps_n(mem_wps_n),
  .mem_bws_n_rise(mem_bws_n_rise), .mem_bws_n_fall(mem_bws_n_fall),
  .rsp_valid(rsp_valid)
);

// File: tb/qdr4_ctrl_bench.sv
module qdr4_ctrl_bench;
  localparam int AW = 19, DW = 36, LANES = 4, NB = 4, MD = 64;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic wr_valid = 0, rd_valid = 0, wr_ready, rd_ready, rsp_valid;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, mem_addr;
  logic [NB*DW-1:0] wr_data = '0, rsp_data;
  logic [NB*LANES-1:0] wr_be = '0;
  logic mem_rps_n, mem_wps_n;
  logic [DW-1:0] mem_d_rise, mem_d_fall, mem_q_rise, mem_q_fall;
  logic [LANES-1:0] mem_bws_n_rise, mem_bws_n_fall;
  logic mem_qvld_rise, mem_qvld_fall;

  qdr4_ctrl #(.AW(AW), .DW(DW), .LANES(LANES), .FIFO_DEPTH(4)) u_qdr4_ctrl (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] model [MD][NB];
  logic [DW-1:0] refm  [MD][NB];
  logic [NB*DW-1:0] expq [256];
  int n_exp = 0, n_got = 0, both_low = 0, spacing_bad = 0;
  logic prev_r = 1, prev_w = 1;

  task automatic chk(input bit ok, input string req, input logic [NB*DW-1:0] act, input logic [NB*DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory, sees at negedge n what the part samples at edge n+1
  int wstage = 0;
  logic [5:0] waddr;
  logic rp_v [6];
  logic [5:0] rp_a [6];
  initial begin
    for (int a = 0; a < MD; a++) for (int w = 0; w < NB; w++) begin model[a][w] = '0; refm[a][w] = '0; end
    for (int k = 0; k < 6; k++) begin rp_v[k] = 0; rp_a[k] = '0; end
    mem_q_rise = '0; mem_q_fall = '0; mem_qvld_rise = 0; mem_qvld_fall = 0;
  end

  task automatic mwrite(input int a, input int w, input logic [DW-1:0] d, input logic [LANES-1:0] bn);
    for (int i = 0; i < LANES; i++) if (!bn[i]) model[a][w][9*i +: 9] = d[9*i +: 9];
  endtask

  always @(negedge clk) begin
    if (wstage == 1) begin
      mwrite(waddr, 0, mem_d_rise, mem_bws_n_rise); mwrite(waddr, 1, mem_d_fall, mem_bws_n_fall); wstage = 2;
    end else if (wstage == 2) begin
      mwrite(waddr, 2, mem_d_rise, mem_bws_n_rise); mwrite(waddr, 3, mem_d_fall, mem_bws_n_fall); wstage = 0;
    end
    if (!rst && !mem_wps_n) begin waddr = mem_addr[5:0]; wstage = 1; end
    for (int k = 5; k > 0; k--) begin rp_v[k] = rp_v[k-1]; rp_a[k] = rp_a[k-1]; end
    rp_v[0] = !rst && !mem_rps_n; rp_a[0] = mem_addr[5:0];
    mem_q_rise = DW'({$urandom, $urandom}); mem_q_fall = DW'({$urandom, $urandom});
    mem_qvld_rise = 0; mem_qvld_fall = 0;
    if (rp_v[3]) begin mem_q_fall = model[rp_a[3]][0]; mem_qvld_fall = 1; end
    if (rp_v[4]) begin
      mem_q_rise = model[rp_a[4]][1]; mem_q_fall = model[rp_a[4]][2];
      mem_qvld_rise = 1; mem_qvld_fall = 1;
    end
    if (rp_v[5]) begin mem_q_rise = model[rp_a[5]][3]; mem_qvld_rise = 1; end
    // response monitor and bus monitors
    if (!rst) begin
      if (!mem_rps_n && !mem_wps_n) both_low++;
      if ((!mem_rps_n && !prev_r) || (!mem_wps_n && !prev_w)) spacing_bad++;
      prev_r = mem_rps_n; prev_w = mem_wps_n;
      if (rsp_valid) begin
        chk(n_got < n_exp && rsp_data == expq[n_got], "R6/R7 response data in order", rsp_data, expq[n_got]);
        n_got++;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [NB*DW-1:0] refword(input int a);
    for (int w = 0; w < NB; w++) refword[DW*w +: DW] = refm[a][w];
  endfunction

  task automatic ref_update(input int a, input logic [NB*DW-1:0] d, input logic [NB*LANES-1:0] be);
    for (int w = 0; w < NB; w++) for (int i = 0; i < LANES; i++)
      if (be[LANES*w+i]) refm[a][w][9*i +: 9] = d[DW*w + 9*i +: 9];
  endtask

  bit stall_seen = 0;

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic push_wr(input logic [AW-1:0] a, input logic [NB*DW-1:0] d, input logic [NB*LANES-1:0] be);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    while (!wr_ready) begin stall_seen = 1; @(negedge clk); end
    @(posedge clk); ref_update(a[5:0], d, be);
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    rd_valid = 1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(posedge clk); expq[n_exp] = refword(a[5:0]); n_exp++;
    @(negedge clk); rd_valid = 0;
  endtask

  function automatic logic [NB*DW-1:0] rnd144();
    return (NB*DW)'({$urandom, $urandom, $urandom, $urandom, $urandom});
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    // R1
    chk(mem_rps_n && mem_wps_n && !rsp_valid, "R1 selects idle after reset", {mem_rps_n, mem_wps_n, rsp_valid}, 3'b110);
    chk(mem_bws_n_rise == '1 && mem_bws_n_fall == '1, "R1 lane selects high", {mem_bws_n_rise, mem_bws_n_fall}, 8'hFF);
    chk(wr_ready && rd_ready, "R1 ready after reset", {wr_ready, rd_ready}, 2'b11);
  endtask

  task automatic t_write_bus();
    logic [NB*DW-1:0] d = rnd144();
    logic [NB*LANES-1:0] be = 16'b1010_0110_1111_0001;
    push_wr(19'h4_0005, d, be);
    chk(mem_wps_n, "R2 no select one cycle after accept", mem_wps_n, 1);
    @(negedge clk);
    chk(!mem_wps_n && mem_addr == 19'h4_0005, "R2 write select and address", {mem_wps_n, mem_addr}, {1'b0, 19'h4_0005});
    @(negedge clk);
    // R3 words 0,1
    chk(mem_wps_n && mem_d_rise == d[35:0] && mem_d_fall == d[71:36], "R3 words 0 and 1",
        {mem_d_fall, mem_d_rise}, d[71:0]);
    chk(mem_bws_n_rise == ~be[3:0] && mem_bws_n_fall == ~be[7:4], "R3 lane selects beat 1",
        {mem_bws_n_fall, mem_bws_n_rise}, ~be[7:0]);
    @(negedge clk);
    chk(mem_d_rise == d[107:72] && mem_d_fall == d[143:108] && mem_bws_n_rise == ~be[11:8] && mem_bws_n_fall == ~be[15:12],
        "R3 words 2 and 3", {mem_d_fall, mem_d_rise}, d[143:72]);
    @(negedge clk);
    // R12
    chk(mem_bws_n_rise == '1 && mem_bws_n_fall == '1, "R12 lane selects idle after burst",
        {mem_bws_n_rise, mem_bws_n_fall}, 8'hFF);
    idle(4);
  endtask

  task automatic t_read_latency();
    int n = 1;
    push_rd(19'h4_0005);
    @(negedge clk);
    // R5
    chk(!mem_rps_n && mem_addr == 19'h4_0005, "R5 read select and address", {mem_rps_n, mem_addr}, {1'b0, 19'h4_0005});
    @(negedge clk); n++;
    chk(mem_rps_n, "R5 read select single cycle", mem_rps_n, 1);
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 7, "R6 response latency", n, 7);
    idle(4);
  endtask

  task automatic t_masked_random();
    for (int k = 0; k < 16; k++) push_wr(AW'(16 + k), rnd144(), 16'($urandom));
    idle(30);
    for (int k = 0; k < 16; k++) push_rd(AW'(16 + k)); // R4 R7 back-to-back reads
    idle(20);
    chk(n_got == n_exp, "R4/R7 all masked reads returned", n_got, n_exp);
  endtask

  task automatic t_concurrent();
    logic [NB*DW-1:0] d = rnd144();
    // R10: read 16 and write 40 offered together
    wr_valid = 1; wr_addr = 40; wr_data = d; wr_be = '1;
    rd_valid = 1; rd_addr = 16;
    chk(wr_ready && rd_ready, "R10 both sides ready", {wr_ready, rd_ready}, 2'b11);
    @(posedge clk); expq[n_exp] = refword(16); n_exp++; ref_update(40, d, '1);
    @(negedge clk); wr_valid = 0; rd_valid = 0;
    idle(12);
    push_rd(40);
    idle(12);
    chk(n_got == n_exp, "R10 both requests completed", n_got, n_exp);
  endtask

  task automatic t_backpressure();
    stall_seen = 0;
    for (int k = 0; k < 10; k++) push_wr(AW'(48 + k), rnd144(), '1);
    chk(stall_seen, "R11 wr_ready fell when FIFO full", stall_seen, 1);
    idle(30);
    for (int k = 0; k < 10; k++) push_rd(AW'(48 + k));
    idle(20);
    chk(n_got == n_exp, "R11 no write lost", n_got, n_exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_bus();
    t_read_latency();
    t_masked_random();
    t_concurrent();
    t_backpressure();
    // R8 R9
    chk(spacing_bad == 0, "R8 select spacing", spacing_bad, 0);
    chk(both_low == 0, "R9 one select per cycle", both_low, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule